// File: doc/BRIEF.md
# Clock-Enable Power-Down Manager

This block sits on the controller side of a two-bank synchronous graphics DRAM and owns the clock-enable pin. It watches every command that the command path issues and keeps a per-bank open/closed flag from those commands and their bank-select bit. When both banks are closed and nothing has asked for the memory for a programmable number of cycles, it drops clock-enable so the memory goes into power-down. While clock-enable is low it freezes the command, bank and address outputs at a NOP.

A host request or a refresh-due signal brings the memory back. Clock-enable rises first. The block then drives one full cycle of NOP with the ready output still low, so the memory is awake before any real command reaches it. Only then does it raise ready. The command path may issue a command only in a cycle where ready is high. All outputs to the memory come from registers.

Top module: `ckepd_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, `memCke` is 1, `cmdReady` is 1, `memCmd` is NOP (code 0) and both banks count as closed.
- R2: A command offered with `cmdValid` high while `cmdReady` is high counts as issued. It appears on `memCmd`/`memBank`/`memAddr` after the next rising edge. Any cycle without an issued command drives NOP. The codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4 (one bank, chosen by `cmdBank`), PALL=5 (both banks), REF=6, MRS=7.
- R3: ACT marks the bank named by `cmdBank` open. PRE closes the bank named by `cmdBank`. PALL closes both. Clock-enable never falls while either bank is open.
- R4: The idle counter starts at 0 and counts quiet cycles. A quiet cycle has both banks closed, `hostReq`, `refreshDue` and `cmdValid` low, and `cmdReady` high. At the edge where the counter is at least `idleLimit` in a quiet cycle, `memCke` goes low. With `idleLimit`=L, this is the (L+1)-th consecutive quiet edge.
- R5: A request, a refresh demand or an issued command in the cycle where the counter has reached `idleLimit` prevents power-down entry and restarts the count from 0.
- R6: While `memCke` is low, `cmdReady` is low, `memCmd` stays NOP, `memBank`/`memAddr` keep their last issued values, and `cmdValid` has no effect on outputs or bank state.
- R7: A `hostReq` sampled while `memCke` is low raises `memCke` after that edge. `cmdReady` stays low for exactly one further cycle with NOP driven, then goes high.
- R8: `refreshDue` alone wakes the memory with the same timing as `hostReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| idleLimit | input | CNT_W | Quiet cycles required before power-down entry |
| hostReq | input | 1 | A host request is pending |
| refreshDue | input | 1 | A refresh must be issued soon |
| cmdValid | input | 1 | The command path offers a command |
| cmdCode | input | 3 | Offered command code |
| cmdBank | input | 1 | Bank-select bit for the offered command |
| cmdAddr | input | ADDR_W | Address bits for the offered command |
| memCke | output | 1 | Clock-enable to the memory |
| memCmd | output | 3 | Registered command code to the memory |
| memBank | output | 1 | Registered bank-select bit to the memory |
| memAddr | output | ADDR_W | Registered address to the memory |
| cmdReady | output | 1 | The command path may issue in this cycle |

## Verification
Three events can fall on the same edge: the idle counter reaching its terminal value, a new request or refresh demand, and a command being issued. The request or command must win, and power-down must not begin. Directed sequences let the counter reach `idleLimit` and then raise `hostReq`, `refreshDue` or `cmdValid` in exactly that cycle. The bench then checks that `memCke` stays high and that a full (L+1)-cycle quiet run is needed again. A seeded random phase with short bursts of quiet cycles hits these collisions many more times. A cycle-level reference model, built only from the requirements, judges each cycle.

// File: rtl/ckepd_pkg.sv
package ckepd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PALL = 3'd5,
    CMD_REF  = 3'd6,
    CMD_MRS  = 3'd7
  } memCmd_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PDN  = 2'd1,
    ST_WAKE = 2'd2
  } pdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;   // command accepted this cycle
    logic drive;   // command register may update (clock enabled)
    logic cntClr;  // restart idle count
    logic cntInc;  // advance idle count
  } dpStrobe_t;

endpackage

// File: rtl/ckepd_dp.sv
module ckepd_dp
  import ckepd_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 10,
  parameter int BANKS  = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   stb,
  input  logic [2:0]                  cmdCode,
  input  logic [$clog2(BANKS)-1:0]    cmdBank,
  input  logic [ADDR_W-1:0]           cmdAddr,
  input  logic [CNT_W-1:0]            idleLimit,
  output logic                        allIdle,
  output logic                        cntAtLimit,
  output logic [2:0]                  memCmd,
  output logic [$clog2(BANKS)-1:0]    memBank,
  output logic [ADDR_W-1:0]           memAddr
);

  localparam int BANK_W = $clog2(BANKS);

  logic [BANKS-1:0] bankOpen;
  logic [CNT_W-1:0] idleCnt;
  memCmd_e          inCmd;

  assign inCmd = memCmd_e'(cmdCode);

  // per-bank open flags
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (cmdBank == BANK_W'(b));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankOpen[b] <= 1'b0;
      end else if (stb.issue) begin
        unique case (inCmd)
          CMD_ACT:  if (hit) bankOpen[b] <= 1'b1;
          CMD_PRE:  if (hit) bankOpen[b] <= 1'b0;
          CMD_PALL: bankOpen[b] <= 1'b0;
          default:  bankOpen[b] <= bankOpen[b];
        endcase
      end
    end
  end

  assign allIdle = (bankOpen == '0);

  // idle counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (stb.cntClr) begin
      idleCnt <= '0;
    end else if (stb.cntInc) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  assign cntAtLimit = (idleCnt >= idleLimit);

  // registered command outputs, frozen while clock-enable is low
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memCmd  <= CMD_NOP;
      memBank <= '0;
      memAddr <= '0;
    end else if (stb.drive) begin
      memCmd <= stb.issue ? cmdCode : CMD_NOP;
      if (stb.issue) begin
        memBank <= cmdBank;
        memAddr <= cmdAddr;
      end
    end
  end

  // R3
  pall_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.issue && inCmd == CMD_PALL) |=> allIdle)
    else $error("precharge-all left a bank open");

  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.drive |=> ($stable(memCmd) && $stable(memAddr) && $stable(memBank)))
    else $error("outputs moved while clock disabled");

  // R6
  nop_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.drive |-> (memCmd == CMD_NOP))
    else $error("non-NOP held during power-down");

  // R4
  no_cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntInc |-> !cntAtLimit)
    else $error("idle counter advanced past limit");

endmodule

// File: rtl/ckepd_ctrl.sv
module ckepd_ctrl
  import ckepd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostReq,
  input  logic      refreshDue,
  input  logic      cmdValid,
  input  logic      allIdle,
  input  logic      cntAtLimit,
  output dpStrobe_t stb,
  output logic      memCke,
  output logic      cmdReady
);

  pdState_e state, stateNxt;
  logic wakeReq, quiet, enterPdn;

  assign wakeReq  = hostReq | refreshDue;
  assign quiet    = (state == ST_RUN) && allIdle && !wakeReq && !cmdValid;
  assign enterPdn = quiet && cntAtLimit;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_RUN:  if (enterPdn) stateNxt = ST_PDN;
      ST_PDN:  if (wakeReq)  stateNxt = ST_WAKE;
      ST_WAKE: stateNxt = ST_RUN;
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  always_comb begin
    stb.issue  = (state == ST_RUN) && cmdValid;
    stb.drive  = (state != ST_PDN);
    stb.cntInc = quiet && !cntAtLimit;
    stb.cntClr = !stb.cntInc;
  end

  assign memCke   = (state != ST_PDN);
  assign cmdReady = (state == ST_RUN);

  // R3
  pdn_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memCke |-> allIdle)
    else $error("power-down with a bank open");

  // R4
  pdn_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCke) |-> ($past(cntAtLimit) && $past(allIdle)))
    else $error("clock-enable dropped before idle limit");

  // R6
  ready_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memCke |-> !cmdReady)
    else $error("ready during power-down");

  // R7
  wake_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCke && wakeReq) |=> (memCke && !cmdReady))
    else $error("wake did not raise clock-enable");

  // R7
  wake_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCke) |=> cmdReady)
    else $error("ready not raised after one wake cycle");

  // R7
  ready_after_cke_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdReady) |-> $past(memCke))
    else $error("ready rose without a clock-enabled cycle before it");

endmodule

// File: rtl/ckepd_top.sv
module ckepd_top
  import ckepd_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  idleLimit,
  input  logic              hostReq,
  input  logic              refreshDue,
  input  logic              cmdValid,
  input  logic [2:0]        cmdCode,
  input  logic              cmdBank,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              memCke,
  output logic [2:0]        memCmd,
  output logic              memBank,
  output logic [ADDR_W-1:0] memAddr,
  output logic              cmdReady
);

  localparam int BANKS = 2;

  dpStrobe_t stb;
  logic      allIdle;
  logic      cntAtLimit;

  ckepd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostReq    (hostReq),
    .refreshDue (refreshDue),
    .cmdValid   (cmdValid),
    .allIdle    (allIdle),
    .cntAtLimit (cntAtLimit),
    .stb        (stb),
    .memCke     (memCke),
    .cmdReady   (cmdReady)
  );

  ckepd_dp #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .BANKS  (BANKS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cmdCode    (cmdCode),
    .cmdBank    (cmdBank),
    .cmdAddr    (cmdAddr),
    .idleLimit  (idleLimit),
    .allIdle    (allIdle),
    .cntAtLimit (cntAtLimit),
    .memCmd     (memCmd),
    .memBank    (memBank),
    .memAddr    (memAddr)
  );

endmodule

// File: tb/ckepd_top_tb.sv
module ckepd_top_tb;

  localparam int CNT_W  = 8;
  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [CNT_W-1:0]  lim = 8'd4;
  logic              hReq = 1'b0, rDue = 1'b0, cV = 1'b0, cB = 1'b0;
  logic [2:0]        cC = 3'd0;
  logic [ADDR_W-1:0] cA = '0;
  logic              memCke, memBank, cmdReady;
  logic [2:0]        memCmd;
  logic [ADDR_W-1:0] memAddr;

  int chkCnt = 0, failCnt = 0;
  bit done = 1'b0;

  // reference model state: 0 run, 1 power-down, 2 wake
  int   mSt = 0, mCnt = 0;
  logic [1:0] mOpen = 2'b00;
  int   mCmd = 0, mBank = 0, mAddr = 0;

  always #5 clk = ~clk;

  ckepd_top #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .idleLimit(lim), .hostReq(hReq), .refreshDue(rDue),
    .cmdValid(cV), .cmdCode(cC), .cmdBank(cB), .cmdAddr(cA),
    .memCke(memCke), .memCmd(memCmd), .memBank(memBank), .memAddr(memAddr),
    .cmdReady(cmdReady)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit isQuiet();
    return (mSt == 0) && (mOpen == 2'b00) && !hReq && !rDue && !cV;
  endfunction

  // advance the model by one edge using the currently driven inputs
  task automatic modelEdge();
    bit q;
    q = isQuiet();
    case (mSt)
      0: begin
        mCmd = cV ? int'(cC) : 0;
        if (cV) begin
          mBank = int'(cB);
          mAddr = int'(cA);
          if (cC == 3'd1) mOpen[cB] = 1'b1;
          if (cC == 3'd4) mOpen[cB] = 1'b0;
          if (cC == 3'd5) mOpen = 2'b00;
        end
        if (q && mCnt >= int'(lim)) begin mSt = 1; mCnt = 0; end
        else if (q) mCnt++;
        else mCnt = 0;
      end
      1: begin
        mCnt = 0;
        if (hReq || rDue) mSt = 2;
      end
      default: begin
        mCnt = 0;
        mCmd = 0;
        mSt = 0;
      end
    endcase
  endtask

  task automatic cycle();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check("R4", "memCke", int'(memCke), (mSt != 1) ? 1 : 0);
    check("R7", "cmdReady", int'(cmdReady), (mSt == 0) ? 1 : 0);
    check("R2", "memCmd", int'(memCmd), mCmd);
    check("R2", "memBank", int'(memBank), mBank);
    check("R2", "memAddr", int'(memAddr), mAddr);
  endtask

  task automatic drive(input bit h, input bit r, input bit v, input int c, input bit b, input int a);
    hReq = h; rDue = r; cV = v; cC = 3'(c); cB = b; cA = ADDR_W'(a);
  endtask

  task automatic quietCycles(input int n);
    for (int i = 0; i < n; i++) begin
      drive(0, 0, 0, 0, 0, 0);
      cycle();
    end
  endtask

  // count quiet edges until clock-enable is seen low
  task automatic quietUntilLow(output int n);
    n = 0;
    while (memCke && n < 300) begin
      drive(0, 0, 0, 0, 0, 0);
      cycle();
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      chkCnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", chkCnt - failCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", "memCke", int'(memCke), 1);
    check("R1", "cmdReady", int'(cmdReady), 1);
    check("R1", "memCmd", int'(memCmd), 0);
    rstN = 1'b1;

    // R2 issue ACT bank1
    drive(0, 0, 1, 1, 1, 'h155);
    cycle();
    check("R2", "ACT code", int'(memCmd), 1);
    check("R2", "ACT addr", int'(memAddr), 'h155);

    // R3 open bank blocks power-down
    quietCycles(12);
    check("R3", "cke with bank1 open", int'(memCke), 1);
    drive(0, 0, 1, 4, 0, 'h2aa);
    cycle();
    quietCycles(12);
    check("R3", "cke after PRE other bank", int'(memCke), 1);
    drive(0, 0, 1, 4, 1, 'h2aa);
    cycle();
    quietUntilLow(n);
    check("R4", "quiet edges to entry", n, int'(lim) + 1);

    // R6 command ignored while down
    for (int i = 0; i < 3; i++) begin
      drive(0, 0, 1, 1, 0, 'h3);
      cycle();
      check("R6", "memCmd held", int'(memCmd), 0);
      check("R6", "memAddr held", int'(memAddr), 'h2aa);
      check("R6", "ready low", int'(cmdReady), 0);
    end

    // R8 refresh wake
    drive(0, 1, 0, 0, 0, 0);
    cycle();
    check("R8", "cke up", int'(memCke), 1);
    check("R8", "ready still low", int'(cmdReady), 0);
    check("R8", "nop in wake", int'(memCmd), 0);
    drive(0, 0, 0, 0, 0, 0);
    cycle();
    check("R8", "ready up", int'(cmdReady), 1);
    // ignored ACT must not have opened bank0
    quietUntilLow(n);
    check("R6", "re-entry after ignored ACT", n, int'(lim) + 1);

    // R7 host wake
    drive(1, 0, 0, 0, 0, 0);
    cycle();
    check("R7", "cke up", int'(memCke), 1);
    check("R7", "ready low in wake", int'(cmdReady), 0);
    drive(0, 0, 0, 0, 0, 0);
    cycle();
    check("R7", "ready up", int'(cmdReady), 1);

    // R5 collisions at terminal count
    for (int k = 0; k < 3; k++) begin
      quietCycles(int'(lim));
      if (k == 0) drive(1, 0, 0, 0, 0, 0);
      else if (k == 1) drive(0, 1, 0, 0, 0, 0);
      else drive(0, 0, 1, 2, 0, 'h11);
      cycle();
      check("R5", "no entry on collision", int'(memCke), 1);
      quietUntilLow(n);
      check("R5", "full count after collision", n, int'(lim) + 1);
      drive(1, 0, 0, 0, 0, 0);
      cycle();
      drive(0, 0, 0, 0, 0, 0);
      cycle();
    end

    // limit 0: entry on first quiet edge
    lim = 8'd0;
    quietUntilLow(n);
    check("R4", "limit zero entry", n, 1);
    drive(0, 1, 0, 0, 0, 0);
    cycle();
    drive(0, 0, 0, 0, 0, 0);
    cycle();

    // seeded random phase
    for (int i = 0; i < 6000; i++) begin
      int r, c;
      r = int'($urandom_range(0, 99));
      c = int'($urandom_range(0, 7));
      if ($urandom_range(0, 2) == 0) c = 5;
      drive(r < 4, r >= 4 && r < 7, $urandom_range(0, 99) < 12, c,
            1'($urandom_range(0, 1)), int'($urandom_range(0, 1023)));
      if ($urandom_range(0, 299) == 0) lim = CNT_W'($urandom_range(0, 6));
      cycle();
      if ($urandom_range(0, 39) == 0) quietCycles(int'($urandom_range(1, 10)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", chkCnt - failCnt, chkCnt);
    $finish;
  end

endmodule